// File: doc/BRIEF.md
# Peripheral Power-Up and Register Write Sequencer

This block brings an external device out of power-down after a system reset and then loads a handful of its registers over a two-wire serial bus. It first walks two active-low control pins through timed phases. The power-down pin is held low and then raised. After that the hardware reset pin is pulsed low and raised again. Each phase lasts a programmable number of system clock cycles. Only when the last settling phase has elapsed does any bus traffic start.

The bus side is a write-only I2C master. Both lines are open-drain. The block only drives a line low or lets it float, and it reads both lines back through two-flop synchronisers. Every register write is its own transaction: START, the device write address, the register index, the value, and STOP. The master checks the acknowledge after every byte. It honours clock stretching on every bit by waiting until SCL really reads high. A missing acknowledge or an SCL line that stays low for too long ends the sequence with an error flag. Busy, done and error flags show where the sequence stands.

Top module: `periph_bringup`

## Requirements
- R1: While rst_n is low, the power-down pin is low, the reset pin is high, neither bus line is driven low, busy is 1, and done and err are 0.
- R2: After rst_n rises, the power-down pin stays low for PD_LOW_CYC cycles. Both pins are then high for PD_HIGH_CYC cycles. The reset pin is then low for RST_LOW_CYC cycles. No bus line is driven low until at least RST_HIGH_CYC cycles after the reset pin rises again. The reset pin is never low while the power-down pin is low.
- R3: A START drives SDA low while SCL is released, then drives SCL low exactly HALF_CYC cycles later.
- R4: For each list entry k, in ascending k, one transaction carries three bytes, each sent MSB first. They are the address byte {DEV_ADDR, 0} (0xB8 for the default 7-bit address 0x5C), then byte k of REG_ADDRS (bits 8k+7..8k), then byte k of REG_VALS. The transaction is framed by a START and a STOP.
- R5: SDA changes only while the master holds SCL low. The only exceptions are the SDA fall of a START and the SDA release of a STOP, both of which happen with SCL high.
- R6: After releasing SCL, the master counts the HALF_CYC high time only while the synchronised SCL reads high. It never pulls SCL low while SCL is being held low by the device.
- R7: During the ninth clock of each byte the master leaves SDA released. A low SDA at the end of the high time is an acknowledge, and the sequence continues.
- R8: A high SDA in an acknowledge slot ends the transaction with a STOP and no further byte. No later transaction starts. err goes to 1, busy and done are 0, and this state holds until reset.
- R9: If SCL reads low for TMO_CYC cycles while the master is waiting for it to rise, err goes to 1 and both lines are released.
- R10: After the last entry is acknowledged and its STOP is sent, done goes to 1, busy goes to 0 and both lines are released. Exactly one of busy, done and err is 1 in every cycle.
- R11: Every phase in which the master drives SCL low lasts exactly HALF_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; sequence starts when it rises |
| pwrdn_n_o | output | 1 | Active-low power-down pin of the device |
| hwrst_n_o | output | 1 | Active-low hardware reset pin of the device |
| scl_i | input | 1 | SCL line level read back from the bus |
| sda_i | input | 1 | SDA line level read back from the bus |
| scl_low_o | output | 1 | 1 drives SCL low, 0 releases it |
| sda_low_o | output | 1 | 1 drives SDA low, 0 releases it |
| busy_o | output | 1 | Sequence still in progress |
| done_o | output | 1 | All writes acknowledged and completed |
| err_o | output | 1 | Sequence aborted on a missing acknowledge or an SCL timeout |

## Verification
The assertions assume that the bus inputs are plain wired-AND levels of the master's drive and the device's drive. They also assume that the device changes SDA only while SCL is low, so that the sampled acknowledge is stable across the synchronisers. The bench device model respects this. It updates its SDA and SCL holds only on the falling clock edge and only after it has seen SCL low. Its random stretches only lengthen a low phase the master has already started. Random acknowledge-failure positions and stretch lengths come from a fixed seed. Directed runs cover a failure on the first address byte, on a mid-list data byte and on the final byte, plus an SCL line that is never released.

// File: rtl/periph_bringup_pkg.sv
// Shared state encodings for the peripheral bring-up sequencer.
// Assumes nothing beyond being compiled before the modules that import it.
package periph_bringup_pkg;

    // Phases of the control-pin walk, in the order they are visited.
    typedef enum logic [2:0] {
        PS_PD_LOW,
        PS_PD_HIGH,
        PS_RST_LOW,
        PS_RST_HIGH,
        PS_READY
    } pin_state_e;

    // Bit-level states of the write-only bus master.
    typedef enum logic [3:0] {
        BS_IDLE,
        BS_START,
        BS_BIT_LO,
        BS_BIT_HI,
        BS_ACK_LO,
        BS_ACK_HI,
        BS_STOP_LO,
        BS_STOP_HI,
        BS_BUS_FREE
    } bus_state_e;

    // Sequencing of the register list at the top level.
    typedef enum logic [2:0] {
        TS_PINS,
        TS_LAUNCH,
        TS_WAIT,
        TS_DONE,
        TS_FAIL
    } top_state_e;

    localparam int unsigned BYTES_PER_WRITE = 3;

endpackage

// File: rtl/pb_sync2.sv
// Two-flop synchroniser for a vector of asynchronous line levels.
// Assumes each bit is independent; reset value chosen per bit by RESET_VAL.
module pb_sync2 #(
    parameter int unsigned        WIDTH     = 2,
    parameter logic [WIDTH-1:0]   RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [1:0] pipe;

        // Shift the raw level through two flops.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= {2{RESET_VAL[i]}};
            else        pipe <= {pipe[0], d_i[i]};
        end

        assign q_o[i] = pipe[1];
    end

endmodule

// File: rtl/pb_pin_seq.sv
// Walks the power-down and hardware-reset pins of the device through four
// timed phases after reset, then raises ready_o.
// Assumes every phase length parameter is at least 1.
module pb_pin_seq
    import periph_bringup_pkg::*;
#(
    parameter int unsigned PD_LOW_CYC   = 50_000,
    parameter int unsigned PD_HIGH_CYC  = 50_000,
    parameter int unsigned RST_LOW_CYC  = 50_000,
    parameter int unsigned RST_HIGH_CYC = 50_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic pwrdn_n_o,
    output logic hwrst_n_o,
    output logic ready_o
);

    localparam int unsigned MAX_A = (PD_LOW_CYC  > PD_HIGH_CYC)  ? PD_LOW_CYC  : PD_HIGH_CYC;
    localparam int unsigned MAX_B = (RST_LOW_CYC > RST_HIGH_CYC) ? RST_LOW_CYC : RST_HIGH_CYC;
    localparam int unsigned MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CW    = (MAXC < 2) ? 1 : $clog2(MAXC);

    pin_state_e    state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last_cnt;

    // Select the terminal count of the current phase.
    always_comb begin
        unique case (state)
            PS_PD_LOW:   last_cnt = CW'(PD_LOW_CYC - 1);
            PS_PD_HIGH:  last_cnt = CW'(PD_HIGH_CYC - 1);
            PS_RST_LOW:  last_cnt = CW'(RST_LOW_CYC - 1);
            PS_RST_HIGH: last_cnt = CW'(RST_HIGH_CYC - 1);
            default:     last_cnt = '0;
        endcase
    end

    // Advance phases and update the two pins in step with them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= PS_PD_LOW;
            cnt       <= '0;
            pwrdn_n_o <= 1'b0;
            hwrst_n_o <= 1'b1;
        end else if (state != PS_READY) begin
            if (cnt == last_cnt) begin
                cnt <= '0;
                unique case (state)
                    PS_PD_LOW:   begin state <= PS_PD_HIGH;  pwrdn_n_o <= 1'b1; end
                    PS_PD_HIGH:  begin state <= PS_RST_LOW;  hwrst_n_o <= 1'b0; end
                    PS_RST_LOW:  begin state <= PS_RST_HIGH; hwrst_n_o <= 1'b1; end
                    default:     state <= PS_READY;
                endcase
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign ready_o = (state == PS_READY);

    // R2: the reset pin only goes low once power-down has been lifted.
    p_rst_after_pd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hwrst_n_o |-> pwrdn_n_o);

    // R2: power-down is never re-entered once lifted.
    p_pd_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn_n_o |=> pwrdn_n_o);

    // R2: ready only with both pins released.
    p_ready_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (pwrdn_n_o && hwrst_n_o));

endmodule

// File: rtl/pb_i2c_writer.sv
// Write-only open-drain bus master: sends START, three bytes MSB first with
// an acknowledge check after each, then STOP. Waits for SCL to read high on
// every clock (stretching) and gives up after TMO_CYC cycles of a low SCL.
// Assumes scl_in_i / sda_in_i are already synchronised; go_i is a one-cycle
// request accepted only in BS_IDLE. done_o pulses at the end; nack_o is valid
// with it. tmo_o pulses on a timeout abort (no done_o then).
module pb_i2c_writer
    import periph_bringup_pkg::*;
#(
    parameter int unsigned HALF_CYC = 250,
    parameter int unsigned TMO_CYC  = 500_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go_i,
    input  logic [23:0] frame_i,
    input  logic        scl_in_i,
    input  logic        sda_in_i,
    output logic        scl_low_o,
    output logic        sda_low_o,
    output logic        done_o,
    output logic        nack_o,
    output logic        tmo_o
);

    localparam int unsigned HW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
    localparam int unsigned TW = (TMO_CYC  < 2) ? 1 : $clog2(TMO_CYC);
    localparam logic [1:0]  LAST_BYTE = 2'(BYTES_PER_WRITE - 1);

    bus_state_e    state;
    logic [HW-1:0] hcnt;
    logic [TW-1:0] tcnt;
    logic [2:0]    bit_idx;
    logic [1:0]    byte_idx;
    logic [7:0]    shreg;
    logic [23:0]   frame_q;
    logic          half_done;
    logic          tmo_hit;
    logic [7:0]    next_byte;

    // Terminal counts and the byte that follows the current one.
    always_comb begin
        half_done = (hcnt == HW'(HALF_CYC - 1));
        tmo_hit   = (tcnt == TW'(TMO_CYC - 1));
        next_byte = (byte_idx == 2'd0) ? frame_q[15:8] : frame_q[7:0];
    end

    // Bus state machine: line drives, bit/byte counters and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= BS_IDLE;
            hcnt      <= '0;
            tcnt      <= '0;
            bit_idx   <= '0;
            byte_idx  <= '0;
            shreg     <= '0;
            frame_q   <= '0;
            scl_low_o <= 1'b0;
            sda_low_o <= 1'b0;
            done_o    <= 1'b0;
            nack_o    <= 1'b0;
            tmo_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            tmo_o  <= 1'b0;
            unique case (state)
                BS_IDLE: begin
                    scl_low_o <= 1'b0;
                    sda_low_o <= 1'b0;
                    if (go_i) begin
                        frame_q   <= frame_i;
                        shreg     <= frame_i[23:16];
                        byte_idx  <= '0;
                        bit_idx   <= '0;
                        nack_o    <= 1'b0;
                        hcnt      <= '0;
                        sda_low_o <= 1'b1;
                        state     <= BS_START;
                    end
                end
                BS_START: begin
                    if (half_done) begin
                        hcnt      <= '0;
                        scl_low_o <= 1'b1;
                        sda_low_o <= ~shreg[7];
                        state     <= BS_BIT_LO;
                    end else hcnt <= hcnt + 1'b1;
                end
                BS_BIT_LO, BS_ACK_LO, BS_STOP_LO: begin
                    if (half_done) begin
                        hcnt      <= '0;
                        tcnt      <= '0;
                        scl_low_o <= 1'b0;
                        state     <= (state == BS_BIT_LO) ? BS_BIT_HI :
                                     (state == BS_ACK_LO) ? BS_ACK_HI : BS_STOP_HI;
                    end else hcnt <= hcnt + 1'b1;
                end
                BS_BIT_HI, BS_ACK_HI, BS_STOP_HI: begin
                    if (!scl_in_i) begin
                        if (tmo_hit) begin
                            scl_low_o <= 1'b0;
                            sda_low_o <= 1'b0;
                            tmo_o     <= 1'b1;
                            hcnt      <= '0;
                            tcnt      <= '0;
                            state     <= BS_IDLE;
                        end else tcnt <= tcnt + 1'b1;
                    end else if (half_done) begin
                        hcnt <= '0;
                        if (state == BS_BIT_HI) begin
                            scl_low_o <= 1'b1;
                            if (bit_idx == 3'd7) begin
                                sda_low_o <= 1'b0;
                                state     <= BS_ACK_LO;
                            end else begin
                                bit_idx   <= bit_idx + 1'b1;
                                shreg     <= {shreg[6:0], 1'b0};
                                sda_low_o <= ~shreg[6];
                                state     <= BS_BIT_LO;
                            end
                        end else if (state == BS_ACK_HI) begin
                            scl_low_o <= 1'b1;
                            if (sda_in_i || byte_idx == LAST_BYTE) begin
                                nack_o    <= sda_in_i;
                                sda_low_o <= 1'b1;
                                state     <= BS_STOP_LO;
                            end else begin
                                byte_idx  <= byte_idx + 1'b1;
                                bit_idx   <= '0;
                                shreg     <= next_byte;
                                sda_low_o <= ~next_byte[7];
                                state     <= BS_BIT_LO;
                            end
                        end else begin
                            sda_low_o <= 1'b0;
                            state     <= BS_BUS_FREE;
                        end
                    end else hcnt <= hcnt + 1'b1;
                end
                BS_BUS_FREE: begin
                    if (half_done) begin
                        hcnt   <= '0;
                        done_o <= 1'b1;
                        state  <= BS_IDLE;
                    end else hcnt <= hcnt + 1'b1;
                end
                default: state <= BS_IDLE;
            endcase
        end
    end

    // R6: while the line is held low by the device, SCL is not re-driven.
    p_wait_stretch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == BS_BIT_HI || state == BS_ACK_HI) && !scl_in_i) |=> !scl_low_o);

    // R7: SDA is left to the device across the acknowledge clock.
    p_ack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BS_ACK_HI) |-> !sda_low_o);

    // R5: with SCL released, SDA moves only for START, STOP or an abort.
    p_sda_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_low_o && !$past(scl_low_o) && !tmo_o &&
         $past(state) != BS_IDLE && $past(state) != BS_STOP_HI) |-> $stable(sda_low_o));

    // R9: a timeout leaves both lines released.
    p_tmo_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_o |-> (!scl_low_o && !sda_low_o));

endmodule

// File: rtl/periph_bringup.sv
// Top of the bring-up sequencer: runs the pin walk, then issues one bus
// write per list entry in ascending order, stopping on the first error.
// Assumes scl_i / sda_i are the wired-AND line levels (asynchronous).
// Entry k of REG_ADDRS / REG_VALS sits in bits [8k+7:8k].
module periph_bringup
    import periph_bringup_pkg::*;
#(
    parameter int unsigned         PD_LOW_CYC   = 50_000,
    parameter int unsigned         PD_HIGH_CYC  = 50_000,
    parameter int unsigned         RST_LOW_CYC  = 50_000,
    parameter int unsigned         RST_HIGH_CYC = 50_000,
    parameter int unsigned         HALF_CYC     = 250,
    parameter int unsigned         TMO_CYC      = 500_000,
    parameter int unsigned         NUM_WR       = 2,
    parameter logic [6:0]          DEV_ADDR     = 7'h5C,
    parameter logic [NUM_WR*8-1:0] REG_ADDRS    = 16'h0300,
    parameter logic [NUM_WR*8-1:0] REG_VALS     = 16'h0D00
) (
    input  logic clk,
    input  logic rst_n,
    output logic pwrdn_n_o,
    output logic hwrst_n_o,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_low_o,
    output logic sda_low_o,
    output logic busy_o,
    output logic done_o,
    output logic err_o
);

    localparam int unsigned IW = (NUM_WR < 2) ? 1 : $clog2(NUM_WR);

    top_state_e    state;
    logic [IW-1:0] idx;
    logic          pins_ready;
    logic [1:0]    lines_sync;
    logic          eng_go;
    logic [23:0]   eng_frame;
    logic          eng_done;
    logic          eng_nack;
    logic          eng_tmo;

    pb_pin_seq #(
        .PD_LOW_CYC   (PD_LOW_CYC),
        .PD_HIGH_CYC  (PD_HIGH_CYC),
        .RST_LOW_CYC  (RST_LOW_CYC),
        .RST_HIGH_CYC (RST_HIGH_CYC)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwrdn_n_o (pwrdn_n_o),
        .hwrst_n_o (hwrst_n_o),
        .ready_o   (pins_ready)
    );

    pb_sync2 #(
        .WIDTH     (2),
        .RESET_VAL (2'b11)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (lines_sync)
    );

    // Build the three-byte frame of the current list entry.
    always_comb begin
        eng_go    = (state == TS_LAUNCH);
        eng_frame = {DEV_ADDR, 1'b0,
                     REG_ADDRS[int'(idx)*8 +: 8],
                     REG_VALS[int'(idx)*8 +: 8]};
    end

    pb_i2c_writer #(
        .HALF_CYC (HALF_CYC),
        .TMO_CYC  (TMO_CYC)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (eng_go),
        .frame_i   (eng_frame),
        .scl_in_i  (lines_sync[1]),
        .sda_in_i  (lines_sync[0]),
        .scl_low_o (scl_low_o),
        .sda_low_o (sda_low_o),
        .done_o    (eng_done),
        .nack_o    (eng_nack),
        .tmo_o     (eng_tmo)
    );

    // Step through the register list and latch the final outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TS_PINS;
            idx   <= '0;
        end else begin
            unique case (state)
                TS_PINS:   if (pins_ready) state <= TS_LAUNCH;
                TS_LAUNCH: state <= TS_WAIT;
                TS_WAIT: begin
                    if (eng_tmo) state <= TS_FAIL;
                    else if (eng_done) begin
                        if (eng_nack)                    state <= TS_FAIL;
                        else if (idx == IW'(NUM_WR - 1)) state <= TS_DONE;
                        else begin
                            idx   <= idx + 1'b1;
                            state <= TS_LAUNCH;
                        end
                    end
                end
                default: state <= state;
            endcase
        end
    end

    assign busy_o = (state != TS_DONE) && (state != TS_FAIL);
    assign done_o = (state == TS_DONE);
    assign err_o  = (state == TS_FAIL);

    // R10: exactly one status flag is raised at any time.
    p_flags_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({busy_o, done_o, err_o}) == 1);

    // R10: completion is held until reset.
    p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);

    // R8: an error is held until reset.
    p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R9: after any failure the bus is left floating.
    p_lines_free_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!scl_low_o && !sda_low_o));

    // R2: the bus stays quiet while the pins are still being sequenced.
    p_bus_quiet_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pins_ready |-> (!scl_low_o && !sda_low_o));

endmodule

// File: tb/periph_bringup_bench.sv
`timescale 1ns/1ps
module periph_bringup_bench;

    localparam int HALF = 4;
    localparam int PDL  = 20;
    localparam int PDH  = 15;
    localparam int RL   = 12;
    localparam int RH   = 10;
    localparam int TMO  = 200;
    localparam int NWR  = 3;
    localparam int NBYTES = 3 * NWR;
    localparam logic [NWR*8-1:0] ADDRS = 24'h0F_03_00;
    localparam logic [NWR*8-1:0] VALS  = 24'h0A_3C_A5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwrdn_n, hwrst_n, scl_dl, sda_dl, busy, done, err;
    logic s_hold = 1'b0;
    logic s_sda_low = 1'b0;
    logic scl_line, sda_line;

    assign scl_line = ~(scl_dl | s_hold);
    assign sda_line = ~(sda_dl | s_sda_low);

    always #10 clk = ~clk;

    periph_bringup #(
        .PD_LOW_CYC(PDL), .PD_HIGH_CYC(PDH), .RST_LOW_CYC(RL), .RST_HIGH_CYC(RH),
        .HALF_CYC(HALF), .TMO_CYC(TMO), .NUM_WR(NWR), .DEV_ADDR(7'h5C),
        .REG_ADDRS(ADDRS), .REG_VALS(VALS)
    ) u_periph_bringup (
        .clk(clk), .rst_n(rst_n), .pwrdn_n_o(pwrdn_n), .hwrst_n_o(hwrst_n),
        .scl_i(scl_line), .sda_i(sda_line), .scl_low_o(scl_dl), .sda_low_o(sda_dl),
        .busy_o(busy), .done_o(done), .err_o(err)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // device model state
    int   nack_at = -1, str_max = 0, frz_byte = -1;
    int   nbytes = 0, bitc = 0, starts = 0, stops = 0, stretch_ev = 0, hold_cnt = 0;
    logic in_frame = 1'b0, ack_phase = 1'b0, hold_forever = 1'b0;
    logic pscl = 1'b1, psda = 1'b1, pm_scl = 1'b0;
    logic [7:0] sr = '0;
    logic [7:0] log_b [0:31];

    // monitor state
    int   run_len = 0, runs = 0, run_bad = 0, gap_cnt = 0, gap_bad = 0;
    logic in_gap = 1'b0, pm_sda = 1'b0, pm_scl2 = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int g);
        int k = g / 3;
        case (g % 3)
            0:       return 8'hB8;
            1:       return ADDRS[k*8 +: 8];
            default: return VALS[k*8 +: 8];
        endcase
    endfunction

    // Device model step, evaluated on each falling clock edge.
    task slave_step();
        logic c, d;
        c = scl_line;
        d = sda_line;
        if (scl_dl && !pm_scl) begin
            if (frz_byte >= 0 && nbytes == frz_byte && bitc == 2) begin
                s_hold = 1'b1; hold_forever = 1'b1;
            end else if (str_max > 0) begin
                hold_cnt = HALF + $urandom_range(str_max, 1);
                s_hold = 1'b1;
                stretch_ev++;
            end
        end else if (s_hold && !hold_forever) begin
            if (hold_cnt <= 1) s_hold = 1'b0;
            hold_cnt--;
        end
        if (pscl && c && psda && !d) begin
            starts++; in_frame = 1'b1; bitc = 0; ack_phase = 1'b0;
        end else if (pscl && c && !psda && d) begin
            stops++; in_frame = 1'b0;
        end else if (in_frame && !pscl && c && bitc < 8) begin
            sr = {sr[6:0], d};
            bitc++;
            if (bitc == 8) begin
                if (nbytes < 32) log_b[nbytes] = sr;
                nbytes++;
            end
        end else if (in_frame && pscl && !c) begin
            if (bitc == 8 && !ack_phase) begin
                ack_phase = 1'b1;
                s_sda_low = ((nbytes - 1) != nack_at);
            end else if (ack_phase) begin
                ack_phase = 1'b0;
                s_sda_low = 1'b0;
                bitc = 0;
            end
        end
        pscl = c; psda = d; pm_scl = scl_dl;
    endtask

    initial forever begin
        @(negedge clk);
        slave_step();
    end

    // Monitor: SCL low-phase length (R11) and START setup time (R3).
    initial forever begin
        @(negedge clk);
        if (scl_dl) run_len++;
        else if (pm_scl2) begin
            if (run_len != HALF) run_bad++;
            runs++;
            run_len = 0;
        end
        if (in_gap) begin
            if (!scl_dl) gap_cnt++;
            else begin
                if (gap_cnt != HALF) gap_bad++;
                in_gap = 1'b0;
            end
        end else if (!pm_sda && sda_dl && !scl_dl) begin
            in_gap = 1'b1; gap_cnt = 1;
        end
        pm_sda = sda_dl; pm_scl2 = scl_dl;
    end

    task automatic run_case(input int na, input int sm, input int fb, input bit check_pins);
        int n;
        int exp_n;
        int bad;
        rst_n = 1'b0;
        @(posedge clk);
        nack_at = na; str_max = sm; frz_byte = fb;
        nbytes = 0; bitc = 0; starts = 0; stops = 0; stretch_ev = 0; hold_cnt = 0;
        in_frame = 1'b0; ack_phase = 1'b0; hold_forever = 1'b0;
        s_hold = 1'b0; s_sda_low = 1'b0;
        run_len = 0; runs = 0; run_bad = 0; gap_cnt = 0; gap_bad = 0; in_gap = 1'b0;
        repeat (3) @(negedge clk);
        if (check_pins) begin
            chk(pwrdn_n == 1'b0, "R1", "pwrdn in reset", pwrdn_n, 0);
            chk(hwrst_n == 1'b1, "R1", "hwrst in reset", hwrst_n, 1);
            chk({scl_dl, sda_dl} == 2'b00, "R1", "bus drive in reset", {scl_dl, sda_dl}, 0);
            chk({busy, done, err} == 3'b100, "R1", "flags in reset", {busy, done, err}, 4);
        end
        rst_n = 1'b1;
        if (check_pins) begin
            n = 0; while (!pwrdn_n) begin n++; @(negedge clk); end
            chk(n == PDL, "R2", "power-down low cycles", n, PDL);
            n = 0; while (hwrst_n) begin n++; @(negedge clk); end
            chk(n == PDH, "R2", "power-down high cycles", n, PDH);
            n = 0; while (!hwrst_n) begin n++; @(negedge clk); end
            chk(n == RL, "R2", "reset low cycles", n, RL);
            n = 0; while (!sda_dl && !scl_dl) begin n++; @(negedge clk); end
            chk(n >= RH, "R2", "quiet cycles after reset pin rise", n, RH);
        end
        n = 0;
        while (!done && !err && n < 20000) begin n++; @(negedge clk); end
        chk(done || err, "R10", "sequence ended", {done, err}, 1);
        repeat (2) @(negedge clk);
        chk({scl_dl, sda_dl} == 2'b00, "R10", "lines released at end", {scl_dl, sda_dl}, 0);
        chk(run_bad == 0 && runs > 0, "R11", "SCL low phases of wrong length", run_bad, 0);
        chk(gap_bad == 0, "R3", "START setup length errors", gap_bad, 0);
        if (fb >= 0) begin
            chk({busy, done, err} == 3'b001, "R9", "flags after timeout", {busy, done, err}, 1);
            s_hold = 1'b0; hold_forever = 1'b0;
            return;
        end
        if (na >= 0 && na < NBYTES) begin
            exp_n = na + 1;
            chk({busy, done, err} == 3'b001, "R8", "flags after NACK", {busy, done, err}, 1);
            chk(starts == na / 3 + 1, "R8", "transactions started", starts, na / 3 + 1);
        end else begin
            exp_n = NBYTES;
            chk({busy, done, err} == 3'b010, "R7", "flags after all ACKs", {busy, done, err}, 2);
            chk(starts == NWR, "R4", "transactions started", starts, NWR);
        end
        chk(nbytes == exp_n, "R8", "bytes on bus", nbytes, exp_n);
        chk(stops == starts, "R5", "STOP count vs START count", stops, starts);
        bad = 0;
        for (int g = 0; g < exp_n && g < 32; g++) begin
            if (log_b[g] !== exp_byte(g)) begin
                if (bad == 0) chk(1'b0, "R4", "byte value", log_b[g], exp_byte(g));
                bad++;
            end
        end
        if (bad == 0) chk(1'b1, "R4", "byte values", 0, 0);
        if (sm > 0) chk(stretch_ev > 0 && bad == 0, "R6", "stretched run intact", stretch_ev, 1);
        repeat (20) @(negedge clk);
        chk(nbytes == exp_n, "R8", "no traffic after end", nbytes, exp_n);
    endtask

    initial begin
        int na;
        int sm;
        void'($urandom(32'd2024));
        run_case(-1, 0, -1, 1'b1);
        run_case(-1, 2 * HALF, -1, 1'b0);
        run_case(0, 0, -1, 1'b0);
        run_case(5, HALF, -1, 1'b0);
        run_case(NBYTES - 1, 0, -1, 1'b0);
        run_case(-1, 0, 1, 1'b0);
        run_case(-1, 0, 4, 1'b0);
        for (int r = 0; r < 8; r++) begin
            na = $urandom_range(NBYTES + 2, 0);
            if (na >= NBYTES) na = -1;
            sm = $urandom_range(2 * HALF, 0);
            run_case(na, sm, -1, 1'b0);
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule